// File: doc/BRIEF.md
# Parallel All-Pairs Extremum Selector

This block receives N unsigned samples side by side on one wide data bus and reports which of them holds the largest value. When the mode input is set, it reports the smallest value instead. The block does not use a tournament tree of comparators. Instead, every pair of samples is compared at once in a single layer. Each pair is given one magnitude comparator, and the mirrored relation is taken from that comparator's inverted output. A per-input AND over its row of pairwise results gives a one-hot winner vector. From that vector the block forms the winner's binary index and passes the winning sample through a one-hot multiplexer.

A strobe samples the data and the mode. One clock later, the one-hot vector, the index, the value and a valid flag appear from registers. The design is meant for 4 or 8 inputs. It spends comparators to keep the logic path between the input and the register short.

Top module: `extsel_top`

## Requirements
- R1: With `in_mode` = 0 and `in_valid` = 1, the reported value is the largest unsigned sample among all N inputs.
- R2: With `in_mode` = 1 and `in_valid` = 1, the reported value is the smallest unsigned sample among all N inputs.
- R3: When several inputs share the winning value, the input with the lowest index is reported. This holds in both modes.
- R4: After a strobe, `out_onehot` has exactly one bit set, at bit position `out_index`, and `out_value` equals the sample on that lane.
- R5: Results and `out_valid` appear on the first rising edge after the edge that sampled `in_valid` = 1. `out_valid` is 0 one edge after `in_valid` was sampled 0.
- R6: An edge with `in_valid` = 0 leaves `out_onehot`, `out_index` and `out_value` unchanged, whatever the data and mode inputs carry.
- R7: A synchronous active-high `rst` clears `out_valid`, `out_onehot`, `out_index` and `out_value` to zero on the next rising edge.
- R8: Input lane k occupies `in_data[k*W +: W]`, with lane 0 in the least significant bits. Index k in `out_index` and bit k of `out_onehot` refer to that lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe that samples data and mode |
| in_mode | input | 1 | 0 selects largest, 1 selects smallest |
| in_data | input | N*W | N packed unsigned samples |
| out_valid | output | 1 | Registered result is fresh |
| out_onehot | output | N | One-hot winning lane |
| out_index | output | $clog2(N) | Binary winning lane number |
| out_value | output | W | Winning sample |

## Verification
The assertions assume that `in_valid` and `in_mode` are 0 or 1 at every edge, that the data bus carries no unknown bits while the strobe is high, and that reset is held for at least one edge before the first strobe. The stimulus drives every input on the falling edge from known values and asserts reset at the start. It draws samples from a narrow range to force frequent ties and from the full range to reach the extremes. Idle cycles carry changing data and mode values, so any leakage into the held outputs would show.

// File: rtl/extsel_pkg.sv
package extsel_pkg;

    typedef enum logic {
        PICK_MAX = 1'b0,
        PICK_MIN = 1'b1
    } pick_e;

endpackage

// File: rtl/extsel_pair_matrix.sv
module extsel_pair_matrix
    import extsel_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [N*W-1:0] data,
    input  pick_e          pick,
    output logic [N*N-1:0] beats
);

    // beats[r*N+c] = 1 when lane r defeats lane c under the current mode.
    // One comparator per unordered pair; the mirror entry is its inverse.
    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            if (r == c) begin : g_diag
                assign beats[r*N+c] = 1'b1;
            end else if (r < c) begin : g_pair
                logic [W-1:0] lhs;
                logic [W-1:0] rhs;
                logic         low_wins;
                // max: low lane wins when a_r >= a_c
                // min: low lane wins when a_r <= a_c, i.e. a_c >= a_r
                assign lhs      = (pick == PICK_MAX) ? data[r*W +: W] : data[c*W +: W];
                assign rhs      = (pick == PICK_MAX) ? data[c*W +: W] : data[r*W +: W];
                assign low_wins = (lhs >= rhs);
                assign beats[r*N+c] = low_wins;
                assign beats[c*N+r] = ~low_wins;
            end
        end
    end

endmodule

// File: rtl/extsel_winner.sv
module extsel_winner #(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N*N-1:0] beats,
    input  logic [N*W-1:0] data,
    output logic [N-1:0]   onehot,
    output logic [IW-1:0]  index,
    output logic [W-1:0]   value
);

    // A lane wins only when it defeats every other lane.
    for (genvar r = 0; r < N; r++) begin : g_and
        assign onehot[r] = &beats[r*N +: N];
    end

    always_comb begin
        index = '0;
        value = '0;
        for (int k = 0; k < N; k++) begin
            if (onehot[k]) begin
                index = index | IW'(k);
            end
            value = value | (data[k*W +: W] & {W{onehot[k]}});
        end
    end

endmodule

// File: rtl/extsel_top.sv
module extsel_top
    import extsel_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 8,
    localparam int IW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           in_mode,
    input  logic [N*W-1:0] in_data,
    output logic           out_valid,
    output logic [N-1:0]   out_onehot,
    output logic [IW-1:0]  out_index,
    output logic [W-1:0]   out_value
);

    typedef struct packed {
        logic          valid;
        logic [N-1:0]  onehot;
        logic [IW-1:0] index;
        logic [W-1:0]  value;
    } result_t;

    result_t       res_d, res_q;
    logic [N*N-1:0] beats;
    logic [N-1:0]   win_onehot;
    logic [IW-1:0]  win_index;
    logic [W-1:0]   win_value;

    extsel_pair_matrix #(.N(N), .W(W)) u_matrix (
        .data  (in_data),
        .pick  (pick_e'(in_mode)),
        .beats (beats)
    );

    extsel_winner #(.N(N), .W(W), .IW(IW)) u_winner (
        .beats  (beats),
        .data   (in_data),
        .onehot (win_onehot),
        .index  (win_index),
        .value  (win_value)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.onehot = win_onehot;
            res_d.index  = win_index;
            res_d.value  = win_value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid  = res_q.valid;
    assign out_onehot = res_q.onehot;
    assign out_index  = res_q.index;
    assign out_value  = res_q.value;

    // ---------------- assertions ----------------
    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> (!out_valid && out_onehot == '0 && out_index == '0 && out_value == '0));

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_flag_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_onehot) == 1 && out_onehot[out_index]));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_onehot) && $stable(out_index) && $stable(out_value)));

    for (genvar k = 0; k < N; k++) begin : g_bound
        assert_max_bound_R1: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !in_mode) |=> (out_value >= $past(in_data[k*W +: W])));
        assert_min_bound_R2: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_mode) |=> (out_value <= $past(in_data[k*W +: W])));
    end

endmodule

// File: tb/extsel_top_test.sv
`timescale 1ns/1ps
module extsel_top_test;

    localparam int N  = 8;
    localparam int W  = 8;
    localparam int IW = $clog2(N);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_mode = 1'b0;
    logic [N*W-1:0] in_data = '0;
    logic           out_valid;
    logic [N-1:0]   out_onehot;
    logic [IW-1:0]  out_index;
    logic [W-1:0]   out_value;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic           exp_valid  = 1'b0;
    logic [N-1:0]   exp_onehot = '0;
    int             exp_index  = 0;
    logic [W-1:0]   exp_value  = '0;
    logic [N*W-1:0] last_data  = '0;

    always #2.5 clk = ~clk;

    extsel_top #(.N(N), .W(W)) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_mode    (in_mode),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_onehot (out_onehot),
        .out_index  (out_index),
        .out_value  (out_value)
    );

    function automatic int pick_lane(input logic m, input logic [N*W-1:0] d);
        int best = 0;
        for (int k = 1; k < N; k++) begin
            if (m ? (d[k*W +: W] < d[best*W +: W]) : (d[k*W +: W] > d[best*W +: W]))
                best = k;
        end
        return best;
    endfunction

    function automatic logic [N*W-1:0] rand_bus(input int range);
        logic [N*W-1:0] d;
        for (int k = 0; k < N; k++) d[k*W +: W] = W'($urandom % range);
        return d;
    endfunction

    task automatic drive(input logic v, input logic m, input logic [N*W-1:0] d, input string tag);
        in_valid = v;
        in_mode  = m;
        in_data  = d;
        @(posedge clk);
        if (rst) begin
            exp_valid = 0; exp_onehot = '0; exp_index = 0; exp_value = '0;
        end else begin
            exp_valid = v;
            if (v) begin
                exp_index  = pick_lane(m, d);
                exp_onehot = N'(1) << exp_index;
                exp_value  = d[exp_index*W +: W];
                last_data  = d;
            end
        end
        @(negedge clk);
        vectors++;
        if (out_valid !== exp_valid || out_onehot !== exp_onehot ||
            out_index !== IW'(exp_index) || out_value !== exp_value) begin
            errors++;
            $display("FAIL %s: got v=%0b oh=%b idx=%0d val=%0d, expected v=%0b oh=%b idx=%0d val=%0d",
                     tag, out_valid, out_onehot, out_index, out_value,
                     exp_valid, exp_onehot, exp_index, exp_value);
        end
        if (out_valid === 1'b1) begin
            // R4: onehot, index and value agree with each other and the sampled lane
            vectors++;
            if (out_onehot !== (N'(1) << out_index) ||
                out_value !== last_data[out_index*W +: W]) begin
                errors++;
                $display("FAIL R4: got oh=%b idx=%0d val=%0d, expected oh=%b val=%0d",
                         out_onehot, out_index, out_value, N'(1) << out_index,
                         last_data[out_index*W +: W]);
            end
        end
    endtask

    initial begin
        logic [N*W-1:0] d;
        // R7: reset state
        rst = 1'b1;
        drive(1'b1, 1'b0, rand_bus(256), "R7");
        drive(1'b1, 1'b1, rand_bus(256), "R7");
        rst = 1'b0;

        // R8: single distinct lane in each position
        for (int k = 0; k < N; k++) begin
            d = {N{W'(10)}};
            d[k*W +: W] = W'(200);
            drive(1'b1, 1'b0, d, "R8");
            d = {N{W'(100)}};
            d[k*W +: W] = W'(3);
            drive(1'b1, 1'b1, d, "R8");
        end

        // R3: all equal, then dense ties
        drive(1'b1, 1'b0, {N{W'(77)}}, "R3");
        drive(1'b1, 1'b1, {N{W'(77)}}, "R3");
        for (int i = 0; i < 60; i++) drive(1'b1, 1'(i % 2), rand_bus(4), "R3");

        // R1 / R2: full range
        for (int i = 0; i < 80; i++) drive(1'b1, 1'b0, rand_bus(256), "R1");
        for (int i = 0; i < 80; i++) drive(1'b1, 1'b1, rand_bus(256), "R2");

        // extremes
        d = {N{W'(0)}};   d[6*W +: W] = '1;   drive(1'b1, 1'b0, d, "R1");
        d = {N{W'(255)}}; d[5*W +: W] = '0;   drive(1'b1, 1'b1, d, "R2");
        drive(1'b1, 1'b0, {N{W'(255)}}, "R3");
        drive(1'b1, 1'b1, {N{W'(0)}}, "R3");

        // R6: idle cycles with changing data and mode hold the result
        drive(1'b1, 1'b0, rand_bus(256), "R6");
        for (int i = 0; i < 6; i++) drive(1'b0, 1'(i % 2), rand_bus(256), "R6");

        // R5: irregular strobe pattern
        for (int i = 0; i < 80; i++)
            drive(1'($urandom % 2), 1'($urandom % 2), rand_bus(256), "R5");

        // R7: reset in mid-run
        drive(1'b1, 1'b0, rand_bus(256), "R7");
        rst = 1'b1;
        drive(1'b1, 1'b0, rand_bus(256), "R7");
        rst = 1'b0;
        drive(1'b0, 1'b0, rand_bus(256), "R7");
        drive(1'b1, 1'b1, rand_bus(256), "R7");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule